// File: doc/BRIEF.md
# Read-Sampling Delay Trainer

This block tunes the receive sampling delay of a serial flash interface for one chip select at a time. When a training run is started and the interface clock is running above the safe threshold, it first asks the command engine for a three-byte identification read at the safe low rate and keeps that answer as the reference. It then raises the delay setting step by step at the full rate. For each setting it writes the delay word and reads the identification again. It records the passing window and programs a setting inside that window. If the window is too narrow, it turns the delay line off and asks for the clock to be lowered to the safe rate.

The command engine sees a simple handshake. The block holds `id_req` high, with `id_safe` marking the reference read. The engine answers with one `rsp_valid` pulse carrying the three bytes. An answer that never arrives ends the request after a fixed cycle count. The trained code of each chip select is kept, so that a `reapply` pulse can write all of them back to the delay line, for example after a power-state change, without a new run.

Top module: `dlytrn_top`

## Requirements
- R1: A start while `rate_fast` is low makes no identification read. It writes the all-zero delay word for the selected chip select, stores code 0 for it and pulses `train_done` with `train_pass`, `train_bypass` and `slow_req` low.
- R2: A start while `rate_fast` is high issues exactly one reference read with `id_safe` high. This read comes before any full-rate read, and `id_safe` is low on every later read of the run.
- R3: The first response byte is `rsp_data[23:16]` and the second is `rsp_data[15:8]`. If these two bytes are both 0xFF or both 0x00, or the reference read times out, the run ends with `train_bypass` high. No delay word is written and the stored code of that chip select is unchanged.
- R4: The full-rate sweep tests codes 0, STEP, 2·STEP and so on. When the next step would exceed MAX_CODE, the code tested instead is exactly MAX_CODE. Each code's delay word is written before its read. The sweep ends after MAX_CODE has been tested.
- R5: The left edge is the first code whose response equals the reference. The right edge is the last equal code. The sweep stops at the first unequal code that follows a pass.
- R6: A run passes when a pass was seen and right − left ≥ MIN_WIN (80). The programmed code is then left + (right − left)·2/5, rounded down, when left is 0 and right < MAX_CODE. Otherwise it is left + (right − left)/2, rounded down. `train_pass` is raised.
- R7: A run that does not pass and is not bypassed writes the all-zero delay word, stores code 0 and raises `slow_req`.
- R8: A nonzero delay word is bit 15 set with the code in its low bits, and the code is never above MAX_CODE. Code 0 is written as 0x0000.
- R9: A `reapply` pulse in idle writes the stored code word of every chip select, one per cycle, in ascending chip-select order.
- R10: A request with no response ends after TIMEOUT cycles and counts as a mismatch. A response ends the request on the next cycle.
- R11: After reset all outputs are low and every stored code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start a training run (accepted in idle) |
| cs_sel | input | CS_W | Chip select to train |
| rate_fast | input | 1 | Interface clock is above the safe threshold |
| reapply | input | 1 | Rewrite all stored codes to the delay line |
| id_req | output | 1 | Identification read request, held until answered or timed out |
| id_safe | output | 1 | Current request is the reference read at the safe rate |
| rsp_valid | input | 1 | Response strobe from the command engine |
| rsp_data | input | 24 | Three response bytes, first byte in the top bits |
| dly_we | output | 1 | Delay word write strobe |
| dly_cs | output | CS_W | Chip select the delay word belongs to |
| dly_word | output | 16 | Delay word: enable at bit 15, code in low bits |
| train_done | output | 1 | One-cycle end-of-run pulse |
| train_pass | output | 1 | Last run found a wide enough window |
| train_bypass | output | 1 | Last run saw no device |
| slow_req | output | 1 | Request to drop to the safe clock rate |

## Verification
A wrong sweep position shows up at once in the order of the delay-word writes, since every step writes a word before its read. A wrong edge record or a wrong window rule stays hidden until the final write of the run. That write, and the one that `reapply` makes, bring the stored state out; both can be compared with the code worked out from the window the bench model presents. A lost bypass decision shows as a stray delay write or a changed code at the next `reapply`. A handshake counter fault shows as a request held longer than TIMEOUT cycles.

// File: rtl/dlytrn_pkg.sv
`timescale 1ns/1ps
package dlytrn_pkg;

  typedef logic [15:0] code_t;

  typedef enum logic [2:0] {
    S_IDLE, S_REF, S_SET, S_WAIT, S_CMP, S_DEC, S_RAP
  } tstate_t;

  // next sweep code, landing exactly on the top value when a step overshoots
  function automatic code_t step_next(input code_t cur, input code_t step, input code_t maxc);
    logic [16:0] s;
    s = {1'b0, cur} + {1'b0, step};
    if (s > {1'b0, maxc}) return maxc;
    return s[15:0];
  endfunction

  // code chosen inside the passing window
  function automatic code_t pick_code(input code_t lft, input code_t rgt, input code_t maxc);
    logic [17:0] span2;
    code_t diff;
    diff  = rgt - lft;
    span2 = {1'b0, diff, 1'b0};
    if (lft == 16'd0 && rgt < maxc) return lft + code_t'(span2 / 18'd5);
    return lft + (diff >> 1);
  endfunction

  // reference pattern that means nothing answered on the bus
  function automatic logic absent_id(input logic [23:0] id);
    return (id[23:16] == 8'hFF && id[15:8] == 8'hFF) ||
           (id[23:16] == 8'h00 && id[15:8] == 8'h00);
  endfunction

  // delay word: enable in bit 15, clamped code in the low bits, zero disables
  function automatic logic [15:0] enc_word(input code_t code, input code_t maxc);
    code_t c;
    c = (code > maxc) ? maxc : code;
    if (c == 16'd0) return 16'h0000;
    return 16'h8000 | {1'b0, c[14:0]};
  endfunction

endpackage

// File: rtl/dlytrn_req.sv
`timescale 1ns/1ps
module dlytrn_req #(
  parameter int TIMEOUT = 32,
  localparam int TO_W = $clog2(TIMEOUT + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic        rsp_valid,
  input  logic [23:0] rsp_data,
  output logic        id_req,
  output logic        fin,
  output logic        ok,
  output logic [23:0] data,
  output logic        timeout_evt
);
  localparam logic [TO_W-1:0] TO_LIM = TO_W'(TIMEOUT - 1);

  logic [TO_W-1:0] cnt;

  assign timeout_evt = id_req && !rsp_valid && (cnt == TO_LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_req <= 1'b0;
      cnt    <= '0;
      fin    <= 1'b0;
      ok     <= 1'b0;
      data   <= '0;
    end else begin
      fin <= 1'b0;
      if (!id_req) begin
        if (go) begin
          id_req <= 1'b1;
          cnt    <= '0;
        end
      end else if (rsp_valid) begin
        id_req <= 1'b0;
        fin    <= 1'b1;
        ok     <= 1'b1;
        data   <= rsp_data;
      end else if (timeout_evt) begin
        id_req <= 1'b0;
        fin    <= 1'b1;
        ok     <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dlytrn_codes.sv
`timescale 1ns/1ps
module dlytrn_codes
  import dlytrn_pkg::*;
#(
  parameter int NUM_CS = 2,
  localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [CS_W-1:0] wr_idx,
  input  code_t           wr_code,
  input  logic [CS_W-1:0] rd_idx,
  output code_t           rd_code
);
  code_t slot [NUM_CS];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             slot[g] <= '0;
      else if (wr_en && wr_idx == CS_W'(g))   slot[g] <= wr_code;
    end
  end

  always_comb begin
    rd_code = '0;
    for (int i = 0; i < NUM_CS; i++)
      if (rd_idx == CS_W'(i)) rd_code = slot[i];
  end
endmodule

// File: rtl/dlytrn_top.sv
`timescale 1ns/1ps
module dlytrn_top
  import dlytrn_pkg::*;
#(
  parameter int MAX_CODE = 255,
  parameter int STEP     = 10,
  parameter int MIN_WIN  = 80,
  parameter int TIMEOUT  = 32,
  parameter int NUM_CS   = 2,
  localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [CS_W-1:0] cs_sel,
  input  logic            rate_fast,
  input  logic            reapply,
  output logic            id_req,
  output logic            id_safe,
  input  logic            rsp_valid,
  input  logic [23:0]     rsp_data,
  output logic            dly_we,
  output logic [CS_W-1:0] dly_cs,
  output logic [15:0]     dly_word,
  output logic            train_done,
  output logic            train_pass,
  output logic            train_bypass,
  output logic            slow_req
);
  localparam code_t MAXC  = code_t'(MAX_CODE);
  localparam code_t STEPC = code_t'(STEP);
  localparam code_t WINC  = code_t'(MIN_WIN);
  localparam logic [CS_W-1:0] LAST_CS = CS_W'(NUM_CS - 1);

  tstate_t         state;
  logic            go;
  logic            fin, ok;
  logic [23:0]     rdata;
  logic            timeout_evt;
  logic [CS_W-1:0] cs_q, rap_idx;
  logic [23:0]     ref_id;
  code_t           cur, lft, rgt;
  logic            seen, hit;
  logic            st_we;
  logic [CS_W-1:0] st_idx;
  code_t           st_code;
  code_t           rd_code;

  // named events for the checker
  logic  sweep_hit, win_ok, ref_bad;
  code_t win_code;
  assign sweep_hit = ok && (rdata == ref_id);
  assign win_ok    = seen && ((rgt - lft) >= WINC);
  assign win_code  = pick_code(lft, rgt, MAXC);
  assign ref_bad   = !ok || absent_id(rdata);

  dlytrn_req #(.TIMEOUT(TIMEOUT)) u_req (
    .clk(clk), .rst_n(rst_n), .go(go), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .id_req(id_req), .fin(fin), .ok(ok),
    .data(rdata), .timeout_evt(timeout_evt)
  );

  dlytrn_codes #(.NUM_CS(NUM_CS)) u_codes (
    .clk(clk), .rst_n(rst_n), .wr_en(st_we), .wr_idx(st_idx),
    .wr_code(st_code), .rd_idx((state == S_RAP) ? rap_idx : cs_q),
    .rd_code(rd_code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      go           <= 1'b0;
      id_safe      <= 1'b0;
      cs_q         <= '0;
      rap_idx      <= '0;
      ref_id       <= '0;
      cur          <= '0;
      lft          <= '0;
      rgt          <= '0;
      seen         <= 1'b0;
      hit          <= 1'b0;
      st_we        <= 1'b0;
      st_idx       <= '0;
      st_code      <= '0;
      dly_we       <= 1'b0;
      dly_cs       <= '0;
      dly_word     <= '0;
      train_done   <= 1'b0;
      train_pass   <= 1'b0;
      train_bypass <= 1'b0;
      slow_req     <= 1'b0;
    end else begin
      go         <= 1'b0;
      dly_we     <= 1'b0;
      st_we      <= 1'b0;
      train_done <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (reapply) begin
            rap_idx <= '0;
            state   <= S_RAP;
          end else if (start) begin
            cs_q         <= cs_sel;
            train_pass   <= 1'b0;
            train_bypass <= 1'b0;
            slow_req     <= 1'b0;
            if (!rate_fast) begin
              dly_we     <= 1'b1;
              dly_cs     <= cs_sel;
              dly_word   <= 16'h0000;
              st_we      <= 1'b1;
              st_idx     <= cs_sel;
              st_code    <= '0;
              train_done <= 1'b1;
            end else begin
              go      <= 1'b1;
              id_safe <= 1'b1;
              state   <= S_REF;
            end
          end
        end
        S_REF: begin
          if (fin) begin
            id_safe <= 1'b0;
            if (ref_bad) begin
              train_bypass <= 1'b1;
              train_done   <= 1'b1;
              state        <= S_IDLE;
            end else begin
              ref_id <= rdata;
              cur    <= '0;
              lft    <= '0;
              rgt    <= '0;
              seen   <= 1'b0;
              state  <= S_SET;
            end
          end
        end
        S_SET: begin
          dly_we   <= 1'b1;
          dly_cs   <= cs_q;
          dly_word <= enc_word(cur, MAXC);
          go       <= 1'b1;
          state    <= S_WAIT;
        end
        S_WAIT: begin
          if (fin) begin
            hit   <= sweep_hit;
            state <= S_CMP;
          end
        end
        S_CMP: begin
          if (seen && !hit) begin
            state <= S_DEC;
          end else begin
            if (hit) begin
              if (!seen) lft <= cur;
              rgt  <= cur;
              seen <= 1'b1;
            end
            if (cur == MAXC) begin
              state <= S_DEC;
            end else begin
              cur   <= step_next(cur, STEPC, MAXC);
              state <= S_SET;
            end
          end
        end
        S_DEC: begin
          dly_we     <= 1'b1;
          dly_cs     <= cs_q;
          st_we      <= 1'b1;
          st_idx     <= cs_q;
          train_done <= 1'b1;
          if (win_ok) begin
            dly_word   <= enc_word(win_code, MAXC);
            st_code    <= win_code;
            train_pass <= 1'b1;
          end else begin
            dly_word <= 16'h0000;
            st_code  <= '0;
            slow_req <= 1'b1;
          end
          state <= S_IDLE;
        end
        S_RAP: begin
          dly_we   <= 1'b1;
          dly_cs   <= rap_idx;
          dly_word <= enc_word(rd_code, MAXC);
          if (rap_idx == LAST_CS) state <= S_IDLE;
          else                    rap_idx <= rap_idx + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dlytrn_chk.sv
`timescale 1ns/1ps
module dlytrn_chk #(
  parameter int MAX_CODE = 255,
  parameter int TIMEOUT  = 32
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        reapply,
  input logic        dly_we,
  input logic [15:0] dly_word,
  input logic        train_done,
  input logic        train_pass,
  input logic        train_bypass,
  input logic        slow_req,
  input logic        id_req,
  input logic        id_safe,
  input logic        rsp_valid,
  input logic        timeout_evt
);
  logic [31:0] req_age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      req_age <= '0;
    else if (id_req) req_age <= req_age + 1;
    else             req_age <= '0;
  end

  // R8
  word_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dly_we |-> (dly_word == 16'h0000) ||
               (dly_word[15] && dly_word[14:0] != 15'd0 && 32'(dly_word[14:0]) <= MAX_CODE));

  // R6
  outcome_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    train_done |-> !(train_pass && (slow_req || train_bypass)));

  // R10
  req_age_chk: assert property (@(posedge clk) disable iff (!rst_n)
    id_req |-> (req_age < 32'(TIMEOUT)));

  // R10
  rsp_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_req && (rsp_valid || timeout_evt)) |=> !id_req);

  // R2
  safe_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(id_safe) |-> $past(start && !reapply));
endmodule

bind dlytrn_top dlytrn_chk #(.MAX_CODE(MAX_CODE), .TIMEOUT(TIMEOUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .reapply(reapply),
  .dly_we(dly_we), .dly_word(dly_word), .train_done(train_done),
  .train_pass(train_pass), .train_bypass(train_bypass), .slow_req(slow_req),
  .id_req(id_req), .id_safe(id_safe), .rsp_valid(rsp_valid),
  .timeout_evt(timeout_evt)
);

// File: tb/dlytrn_top_tb_top.sv
`timescale 1ns/1ps
module dlytrn_top_tb_top;
  localparam int MAXC = 255;
  localparam int STEPV = 10;
  localparam int WINV = 80;
  localparam logic [23:0] DEV_ID = 24'hC22817;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [0:0]  cs_sel = '0;
  logic        rate_fast = 1'b0;
  logic        reapply = 1'b0;
  logic        id_req, id_safe;
  logic        rsp_valid = 1'b0;
  logic [23:0] rsp_data = '0;
  logic        dly_we;
  logic [0:0]  dly_cs;
  logic [15:0] dly_word;
  logic        train_done, train_pass, train_bypass, slow_req;

  always #2.5 clk = ~clk;

  dlytrn_top dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cs_sel(cs_sel),
    .rate_fast(rate_fast), .reapply(reapply), .id_req(id_req),
    .id_safe(id_safe), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .dly_we(dly_we), .dly_cs(dly_cs), .dly_word(dly_word),
    .train_done(train_done), .train_pass(train_pass),
    .train_bypass(train_bypass), .slow_req(slow_req)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // flash / command engine model
  int win_lo = 0, win_hi = 0, drop_code = -1, ref_mode = 0, act_cs = 0;
  int wr_cnt = 0, safe_rd = 0, fast_rd = 0;
  int log_cs [8];
  int log_word [8];
  logic [15:0] held_word [2];
  int mstate = 0, mcnt = 0;
  bit msilent = 0;

  initial begin
    held_word[0] = '0;
    held_word[1] = '0;
  end

  always @(negedge clk) begin
    if (dly_we) begin
      if (wr_cnt < 8) begin
        log_cs[wr_cnt]   = int'(dly_cs);
        log_word[wr_cnt] = int'(dly_word);
      end
      wr_cnt++;
      held_word[dly_cs] = dly_word;
    end
    case (mstate)
      0: if (id_req) begin
        mcnt = 2;
        mstate = 1;
        if (id_safe) begin
          safe_rd++;
          msilent = (ref_mode == 3);
        end else begin
          fast_rd++;
          msilent = (int'(held_word[act_cs][14:0]) == drop_code);
        end
      end
      1: begin
        if (!id_req) mstate = 0;
        else if (mcnt == 0) begin
          if (!msilent) begin
            int c;
            c = int'(held_word[act_cs][14:0]);
            if (id_safe)
              rsp_data = (ref_mode == 1) ? 24'hFFFF12 :
                         (ref_mode == 2) ? 24'h000034 : DEV_ID;
            else
              rsp_data = (c >= win_lo && c <= win_hi) ? DEV_ID : (DEV_ID ^ 24'h5A5A5A);
            rsp_valid = 1'b1;
            mstate = 2;
          end
        end else mcnt--;
      end
      2: begin rsp_valid = 1'b0; mstate = 3; end
      default: if (!id_req) mstate = 0;
    endcase
  end

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int word_of(input int code);
    return (code == 0) ? 0 : (32768 + code);
  endfunction

  // expected result of a sweep, worked out from the window rules
  task automatic predict(input int lo, input int hi, input int drop,
                         output int code, output int steps, output int good);
    int l = 0, r = 0;
    bit seen = 0;
    steps = 0;
    for (int k = 0; k < 1000; k++) begin
      int c;
      bit m;
      c = (k * STEPV > MAXC) ? MAXC : k * STEPV;
      steps++;
      m = (c >= lo) && (c <= hi) && (c != drop);
      if (seen && !m) break;
      if (m) begin
        if (!seen) l = c;
        r = c;
        seen = 1;
      end
      if (c == MAXC) break;
    end
    good = (seen && (r - l) >= WINV) ? 1 : 0;
    if (!good) code = 0;
    else if (l == 0 && r < MAXC) code = l + ((r - l) * 2) / 5;
    else code = l + (r - l) / 2;
  endtask

  task automatic run(input int cs, input bit fast, input int lo, input int hi,
                     input int drop, input int rmode);
    win_lo = lo; win_hi = hi; drop_code = drop; ref_mode = rmode; act_cs = cs;
    @(negedge clk);
    wr_cnt = 0; safe_rd = 0; fast_rd = 0;
    rate_fast = fast;
    cs_sel = cs[0:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      if (train_done) break;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic sweep_case(input string tag, input int cs, input int lo,
                            input int hi, input int drop, output int code);
    int steps, good;
    predict(lo, hi, drop, code, steps, good);
    run(cs, 1'b1, lo, hi, drop, 0);
    check({tag, " R6 pass flag"}, int'(train_pass), good);
    check({tag, " R7 slow request"}, int'(slow_req), good ? 0 : 1);
    check({tag, " R4 R5 reads tested"}, fast_rd, steps);
    check({tag, " R2 one safe read"}, safe_rd, 1);
    check({tag, " R8 final word"}, int'(held_word[cs]), word_of(code));
    check({tag, " R4 writes"}, wr_cnt, steps + 1);
  endtask

  task automatic do_reapply(input int c0, input int c1, input string tag);
    @(negedge clk);
    wr_cnt = 0;
    reapply = 1'b1;
    @(negedge clk);
    reapply = 1'b0;
    repeat (5) @(negedge clk);
    check({tag, " R9 write count"}, wr_cnt, 2);
    check({tag, " R9 first cs"}, log_cs[0], 0);
    check({tag, " R9 first word"}, log_word[0], word_of(c0));
    check({tag, " R9 second cs"}, log_cs[1], 1);
    check({tag, " R9 second word"}, log_word[1], word_of(c1));
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int c0, c1, cx;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 id_req", int'(id_req), 0);
    check("R11 dly_we", int'(dly_we), 0);
    check("R11 done", int'(train_done), 0);
    check("R11 flags", int'({train_pass, train_bypass, slow_req, id_safe}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    do_reapply(0, 0, "R11 stored");

    sweep_case("T1", 0, 33, 200, -1, c0);
    check("T1 R5 R6 code", c0, 120);
    sweep_case("T2", 1, 0, 150, -1, c1);
    check("T2 R6 two-fifths code", c1, 60);
    do_reapply(c0, c1, "T2");

    // R3 absent device patterns and reference timeout
    for (int m = 1; m <= 3; m++) begin
      run(0, 1'b1, 0, 255, -1, m);
      check("R3 bypass flag", int'(train_bypass), 1);
      check("R3 no delay write", wr_cnt, 0);
      check("R3 no full-rate read", fast_rd, 0);
      check("R3 R6 no pass", int'(train_pass), 0);
    end
    do_reapply(c0, c1, "R3 code kept");

    sweep_case("T6", 0, 0, 255, -1, cx);
    check("T6 R4 top tested mid code", cx, 127);
    sweep_case("T7", 1, 100, 170, -1, cx);
    check("T7 R7 narrow window", cx, 0);
    sweep_case("T8", 0, 170, 255, -1, cx);
    check("T8 R6 mid code", cx, 212);
    sweep_case("T9", 1, 0, 255, 130, cx);
    check("T9 R10 timeout as miss", cx, 48);

    // R1 slow clock
    run(0, 1'b0, 0, 255, -1, 0);
    check("R1 no reads", safe_rd + fast_rd, 0);
    check("R1 one write", wr_cnt, 1);
    check("R1 zero word", int'(held_word[0]), 0);
    check("R1 flags", int'({train_pass, train_bypass, slow_req}), 0);
    do_reapply(0, 48, "R1");

    for (int lo = 0; lo <= 255; lo += 31)
      for (int w = 40; w <= 260; w += 55) begin
        int hi;
        hi = (lo + w > 255) ? 255 : lo + w;
        sweep_case("SWEEP", (lo / 31) % 2, lo, hi, -1, cx);
      end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule